// File: doc/BRIEF.md
# UART Modem Handshake Control and Status Unit

This unit manages the modem handshake lines of one serial channel. A small control register, written over a plain strobe port, sets the request lines that leave the chip. These lines are the data-terminal-ready and request-to-send outputs, both active low. Four active-low inputs come in from the link partner: clear-to-send, data-set-ready, ring indicator and carrier detect. Each passes through a synchronizer. The unit then reports the inputs as an eight-bit status byte. The upper nibble of that byte gives the asserted state of each line. The lower nibble holds sticky change flags that a status read clears. An interrupt request is raised while any flag is set and the modem interrupt enable is high.

A loop control turns the unit back on itself for self-test. In loop mode both outputs are forced inactive, the input pins are ignored, and the status byte follows the control bits instead. The register port carries no stream data. Every read and write completes in the cycle its strobe is high, so it has no valid/ready handshake and no back-pressure. The read data is combinational from `reg_sel` and is valid in the same cycle.

Top module: `modem_ctl_unit`

## Requirements
- R1: Status bits 4, 5, 6 and 7 are the complements of the synchronized cts_n, dsr_n, ri_n and dcd_n pins. A pin change shows in the status three rising edges after the first edge that samples it.
- R2: Status bit 0 (cts), bit 1 (dsr) and bit 3 (dcd) become set when the corresponding pin changes level in either direction. They stay set until a status read.
- R3: Status bit 2 becomes set only when ri_n goes from low to high. A high-to-low change of ri_n leaves it clear.
- R4: When reg_sel=1, rd_en returns the status byte in the same cycle and clears bits 3..0 at the next edge. A change detected at that same edge remains set.
- R5: irq is high exactly when msi_en is high and at least one of status bits 3..0 is set. irq is therefore low while msi_en is low, and low after a read that leaves no flag set.
- R6: wr_en with reg_sel=0 stores wdata[3:0] as the control bits. A read with reg_sel=0 returns {4'b0, control}. Control bit 0 set drives dtr_n low, and control bit 1 set drives rts_n low, whenever loop_en is low.
- R7: After reset, dtr_n and rts_n are 1, the control bits are 0, the status byte is 8'h00 while the pins are idle high, and irq is 0.
- R8: While loop_en is high, dtr_n and rts_n are 1 and the pins are ignored. The cts level follows control bit 1, the dsr level follows bit 0, the ri level follows bit 2 and the dcd level follows bit 3, one edge after the control changes.
- R9: A single pin change sets its flag exactly once. After the flag is cleared it is not set again while the pin stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 1 | 0 selects control register, 1 selects status register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; clears flags when reg_sel=1 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| loop_en | input | 1 | Internal loop mode |
| msi_en | input | 1 | Modem interrupt enable |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| irq | output | 1 | Modem status interrupt request |

## Verification
The assertions check the following on every cycle: the outputs are held inactive in loop mode, the interrupt agrees with the enable and the visible flags, the outputs follow a control write, and the reset values hold. Some behaviours only the bench scenarios can show. These are the synchronizer latency, the direction rule for the ring flag, a change landing on the same edge as a clearing read, and the absence of a repeated flag on a stable pin. A behavioural model in the bench tracks all of these and is compared with the outputs on every cycle.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int unsigned NLINE   = 4;
  localparam int unsigned LN_CTS  = 0;
  localparam int unsigned LN_DSR  = 1;
  localparam int unsigned LN_RI   = 2;
  localparam int unsigned LN_DCD  = 3;
  localparam int unsigned CTL_DTR = 0;
  localparam int unsigned CTL_RTS = 1;
  localparam int unsigned CTL_AUX1 = 2;
  localparam int unsigned CTL_AUX2 = 3;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '1;
        else if (s == 0) chain_q[s] <= pin_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pin_o = chain_q[STAGES-1];
endmodule

// File: rtl/modem_delta.sv
module modem_delta #(
  parameter int unsigned NL     = 4,
  parameter int unsigned RI_IDX = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] lvl_i,
  input  logic          clr_i,
  output logic [NL-1:0] lvl_o,
  output logic [NL-1:0] flag_o
);
  logic [NL-1:0] lvl_q, flag_q, hit;

  generate
    for (genvar i = 0; i < NL; i++) begin : g_line
      if (i == RI_IDX) begin : g_trail
        assign hit[i] = lvl_q[i] & ~lvl_i[i];
      end else begin : g_any
        assign hit[i] = lvl_q[i] ^ lvl_i[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      flag_q <= '0;
    end else begin
      lvl_q  <= lvl_i;
      flag_q <= (clr_i ? '0 : flag_q) | hit;
    end
  end

  assign lvl_o  = lvl_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
  import modem_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              loop_en,
  input  logic              msi_en,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              irq
);
  localparam int unsigned PAD_W = DATA_W - NLINE;

  logic [NLINE-1:0] ctl_q, pins_n, pins_sync_n, loop_lvl, lvl_sel, lvl_cur, flags;
  logic             st_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr_en && !reg_sel) ctl_q <= wdata[NLINE-1:0];
  end

  assign pins_n[LN_CTS] = cts_n;
  assign pins_n[LN_DSR] = dsr_n;
  assign pins_n[LN_RI]  = ri_n;
  assign pins_n[LN_DCD] = dcd_n;

  modem_sync #(.WIDTH(NLINE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pins_n), .pin_o(pins_sync_n)
  );

  assign loop_lvl[LN_CTS] = ctl_q[CTL_RTS];
  assign loop_lvl[LN_DSR] = ctl_q[CTL_DTR];
  assign loop_lvl[LN_RI]  = ctl_q[CTL_AUX1];
  assign loop_lvl[LN_DCD] = ctl_q[CTL_AUX2];

  assign lvl_sel = loop_en ? loop_lvl : ~pins_sync_n;
  assign st_clr  = rd_en && reg_sel;

  modem_delta #(.NL(NLINE), .RI_IDX(LN_RI)) u_delta (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_sel), .clr_i(st_clr),
    .lvl_o(lvl_cur), .flag_o(flags)
  );

  assign rdata = reg_sel ? {{(PAD_W-NLINE){1'b0}}, lvl_cur, flags}
                         : {{PAD_W{1'b0}}, ctl_q};
  assign dtr_n = ~(ctl_q[CTL_DTR] & ~loop_en);
  assign rts_n = ~(ctl_q[CTL_RTS] & ~loop_en);
  assign irq   = msi_en & (|flags);
endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_sel,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       loop_en,
  input logic       msi_en,
  input logic       dtr_n,
  input logic       rts_n,
  input logic       irq
);
  // R8
  loop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (dtr_n && rts_n));

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en |-> !irq);

  // R5
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && msi_en) |-> (irq == (rdata[3:0] != 4'h0)));

  // R6
  dtr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel && wdata[0]) |=> (loop_en || !dtr_n));

  // R6
  rts_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel && !wdata[1]) |=> rts_n);

  // R7
  reset_val_chk: assert property (@(posedge clk)
    !rst_n |=> (dtr_n && rts_n && !irq));
endmodule

bind modem_ctl_unit modem_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .loop_en(loop_en), .msi_en(msi_en),
  .dtr_n(dtr_n), .rts_n(rts_n), .irq(irq)
);

// File: tb/tb_modem_ctl_unit.sv
module tb_modem_ctl_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic loop_en = 1'b0, msi_en = 1'b1;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic dtr_n, rts_n, irq;

  int n_chk = 0;
  int n_fail = 0;

  // model state: index 0 cts, 1 dsr, 2 ri, 3 dcd (asserted = 1)
  bit m_s1 [4];
  bit m_s2 [4];
  bit m_lvl [4];
  bit m_flg [4];
  bit [3:0] m_ctl;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_ctl_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .loop_en(loop_en), .msi_en(msi_en),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic bit [7:0] m_status();
    bit [7:0] v;
    for (int i = 0; i < 4; i++) begin
      v[4+i] = m_lvl[i];
      v[i]   = m_flg[i];
    end
    return v;
  endfunction

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_s1[i] = 1; m_s2[i] = 1; m_lvl[i] = 0; m_flg[i] = 0;
      end
      m_ctl = 4'h0;
    end else begin
      bit now_l [4];
      bit pin [4];
      bit clear;
      pin[0] = cts_n; pin[1] = dsr_n; pin[2] = ri_n; pin[3] = dcd_n;
      if (loop_en) begin
        now_l[0] = m_ctl[1]; now_l[1] = m_ctl[0];
        now_l[2] = m_ctl[2]; now_l[3] = m_ctl[3];
      end else begin
        for (int i = 0; i < 4; i++) now_l[i] = !m_s2[i];
      end
      clear = rd_en && reg_sel;
      for (int i = 0; i < 4; i++) begin
        bit changed;
        if (i == 2) changed = m_lvl[i] && !now_l[i];
        else changed = m_lvl[i] != now_l[i];
        if (clear) m_flg[i] = 0;
        if (changed) m_flg[i] = 1;
        m_lvl[i] = now_l[i];
        m_s2[i] = m_s1[i];
        m_s1[i] = pin[i];
      end
      if (wr_en && !reg_sel) m_ctl = wdata[3:0];
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      bit [7:0] st;
      bit any;
      st = m_status();
      any = |st[3:0];
      if (reg_sel) begin
        check("R1 levels", {rdata[7:4], 4'h0}, {st[7:4], 4'h0});
        check("R2 flags", {4'h0, rdata[3:0]}, {4'h0, st[3:0]});
      end else begin
        check("R6 ctl read", rdata, {4'h0, m_ctl});
      end
      check("R5 irq", {7'h0, irq}, {7'h0, msi_en && any});
      check("R6 dtr", {7'h0, dtr_n}, {7'h0, !(m_ctl[0] && !loop_en)});
      check("R6 rts", {7'h0, rts_n}, {7'h0, !(m_ctl[1] && !loop_en)});
    end
  end

  task automatic do_read();
    reg_sel = 1'b1; rd_en = 1'b1; tick(); rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] v);
    reg_sel = 1'b0; wr_en = 1'b1; wdata = v; tick(); wr_en = 1'b0; reg_sel = 1'b1;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    #3;
    check("R7 status", rdata, 8'h00);
    check("R7 pins", {6'h0, dtr_n, rts_n}, 8'h03);
    check("R7 irq", {7'h0, irq}, 8'h00);

    cts_n = 1'b0; tick(4); #3;
    check("R1 R2 cts fall", rdata, 8'h11);
    check("R5 irq set", {7'h0, irq}, 8'h01);
    do_read(); #3;
    check("R4 clear", rdata, 8'h10);
    check("R5 irq cleared", {7'h0, irq}, 8'h00);
    tick(5); #3;
    check("R9 no refire", rdata, 8'h10);

    ri_n = 1'b0; tick(4); #3;
    check("R3 ri leading", rdata, 8'h50);
    ri_n = 1'b1; tick(4); #3;
    check("R3 ri trailing", rdata, 8'h14);
    do_read();
    dcd_n = 1'b0; tick(4); #3;
    check("R2 dcd", rdata, 8'h98);
    do_read();

    dsr_n = 1'b0; tick(2); rd_en = 1'b1; tick(); rd_en = 1'b0; #3;
    check("R4 same cycle", {7'h0, rdata[1]}, 8'h01);
    do_read(); #3;
    check("R4 cleared", rdata, 8'hB0);

    do_write(8'h03); reg_sel = 1'b0; #3;
    check("R6 ctl value", rdata, 8'h03);
    check("R6 drive low", {6'h0, dtr_n, rts_n}, 8'h00);
    reg_sel = 1'b1;

    loop_en = 1'b1; tick(); #3;
    check("R8 outputs idle", {6'h0, dtr_n, rts_n}, 8'h03);
    do_read(); tick();
    dcd_n = 1'b1; cts_n = 1'b1; tick(5); #3;
    check("R8 pins ignored", rdata, 8'h30);
    do_write(8'h0C); tick(); #3;
    check("R8 loop map", {rdata[7:4], 4'h0}, 8'hC0);

    msi_en = 1'b0; tick(); #3;
    check("R5 disabled", {7'h0, irq}, 8'h00);
    loop_en = 1'b0; tick(6);
    msi_en = 1'b1; tick(); do_read(); tick(3);

    for (int k = 0; k < 40; k++) begin
      cts_n = k[0]; dsr_n = k[1]; ri_n = k[2]; dcd_n = k[3];
      if (k % 5 == 0) do_read(); else tick();
      if (k % 7 == 0) do_write(8'(k));
    end
    tick(6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule